// File: doc/BRIEF.md
# Paging Control Register Write Unit

This block holds the three paging-related processor control registers (the mode register CR0, the page-table base CR3 and the extension register CR4) together with the gate mask for physical address bit 20. Software-visible writes arrive on a single-cycle register-write port that carries a selector and a data word. Each write is stored, with some fields forced or masked on the way in. The block also works out whether the rest of the core must discard its cached translations.

Two kinds of flush are requested. A full flush discards every cached translation. A non-global flush keeps entries marked global. A full flush follows a change in the protection or paging-enable bits of CR0, a change in the page-size or extension bits of CR4, or a change of the address-bit-20 enable input. A non-global flush follows a page-table base write while paging is on. A change of the address gate also raises an execution-exit request, so that code already in flight is abandoned. The block also drives hidden mode flags that the rest of the core reads: protected-mode, address-segment-add, the three FPU-control copies and the extended-save-enable flag.

Top module: `crw_ctrl_regs`

## Requirements
- R1: After reset, cr0_q is 0x60000010, cr3_q and cr4_q are 0, a20_mask is 0xFFFFFFFF, hf_pe, hf_mp, hf_em, hf_ts and hf_osfxsr are 0, hf_addseg is 1, and all three strobes are low.
- R2: A write with wr_sel = 0 stores wr_data in cr0_q with bit 4 forced to one.
- R3: A write with wr_sel = 0 pulses flush_all exactly when bit 31, bit 16 or bit 0 of the stored value differs from the previous cr0_q. A write that changes only other bits gives no flush.
- R4: After a CR0 write, hf_pe equals bit 0 of cr0_q and hf_addseg equals its inverse, so hf_addseg is set whenever protection is off.
- R5: After a CR0 write, hf_mp, hf_em and hf_ts equal cr0_q bits 1, 2 and 3 respectively.
- R6: A write with wr_sel = 1 always stores wr_data in cr3_q. It pulses flush_nonglobal only if cr0_q bit 31 is set at the time of the write.
- R7: A write with wr_sel = 2 pulses flush_all exactly when bit 4, 5 or 7 of the stored value differs from the previous cr4_q.
- R8: On a CR4 write, bit 9 is stored as zero while sse_supported is low. hf_osfxsr always equals cr4_q bit 9.
- R9: When a20_enable differs from the currently gated state, a20_mask becomes 0xFFEFFFFF with bit 20 equal to the new a20_enable, and flush_all and exit_exec pulse together. A steady a20_enable raises neither.
- R10: Strobes are registered: each one is high for the single cycle after the edge that accepted the cause. If a full and a non-global flush are caused at the same edge, only flush_all is raised.
- R11: A write with wr_sel = 3 changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write valid for this cycle |
| wr_sel | input | 2 | Target: 0 mode register, 1 table base, 2 extension register, 3 unused |
| wr_data | input | 32 | Write data |
| sse_supported | input | 1 | High when the extended-save feature exists |
| a20_enable | input | 1 | Requested state of physical address bit 20 |
| cr0_q | output | 32 | Stored mode register |
| cr3_q | output | 32 | Stored page-table base |
| cr4_q | output | 32 | Stored extension register |
| a20_mask | output | 32 | Physical address mask, only bit 20 may be clear |
| hf_pe | output | 1 | Hidden protected-mode flag |
| hf_addseg | output | 1 | Hidden segment-base-add flag |
| hf_mp | output | 1 | Hidden monitor-coprocessor copy |
| hf_em | output | 1 | Hidden FPU-emulate copy |
| hf_ts | output | 1 | Hidden task-switched copy |
| hf_osfxsr | output | 1 | Hidden extended-save-enable flag |
| flush_all | output | 1 | One-cycle full translation flush request |
| flush_nonglobal | output | 1 | One-cycle non-global translation flush request |
| exit_exec | output | 1 | One-cycle execution-exit request |

## Verification
The bench writes CR0 with all-zero data to show that bit 4 is forced on. A design that stored the raw value would read back 0. It then changes only the FPU-copy bits and then only the write-protect bit. A design that compared the whole register would flush on the first, and one that missed a bit group would not flush on the second. A page-table base write is made with paging off and again with it on, so a design that always flushed, or never did, is caught. The extension register is written with sse_supported low. The address gate toggles in the same cycle as a page-table base write, which shows full-flush priority and that a held gate input gives no repeat pulse. An unused-selector write checks that nothing moves.

// File: rtl/crw_pkg.sv
package crw_pkg;

    localparam int CRW_W      = 32;

    localparam int CR0_PE     = 0;
    localparam int CR0_MP     = 1;
    localparam int CR0_EM     = 2;
    localparam int CR0_TS     = 3;
    localparam int CR0_ET     = 4;
    localparam int CR0_WP     = 16;
    localparam int CR0_PG     = 31;

    localparam int CR4_PSE    = 4;
    localparam int CR4_PAE    = 5;
    localparam int CR4_PGE    = 7;
    localparam int CR4_OSFXSR = 9;

    localparam logic [CRW_W-1:0] CR0_RESET = 32'h6000_0010;

    typedef enum logic [1:0] {
        SEL_CR0  = 2'd0,
        SEL_CR3  = 2'd1,
        SEL_CR4  = 2'd2,
        SEL_RSVD = 2'd3
    } crw_sel_e;

    typedef struct packed {
        logic pe;
        logic addseg;
        logic mp;
        logic em;
        logic ts;
    } cr0_flags_t;

    typedef struct packed {
        logic full;
        logic nonglobal;
        logic exit_exec;
    } flush_req_t;

    function automatic cr0_flags_t derive_cr0_flags(input logic [3:0] low_bits);
        cr0_flags_t f;
        f.pe     = low_bits[CR0_PE];
        f.addseg = ~low_bits[CR0_PE];
        f.mp     = low_bits[CR0_MP];
        f.em     = low_bits[CR0_EM];
        f.ts     = low_bits[CR0_TS];
        return f;
    endfunction

    function automatic flush_req_t merge_flush(input logic full_any,
                                               input logic ng_any,
                                               input logic exit_any);
        flush_req_t r;
        r.full      = full_any;
        r.nonglobal = ng_any & ~full_any;
        r.exit_exec = exit_any;
        return r;
    endfunction

endpackage

// File: rtl/crw_cr0_unit.sv
module crw_cr0_unit
    import crw_pkg::*;
#(
    parameter int DATA_W = CRW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cr0_q,
    output cr0_flags_t        flags_q,
    output logic              flush_req
);

    localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(CR0_RESET);

    logic [DATA_W-1:0] next_val;
    logic              pg_chg;
    logic              wp_chg;
    logic              pe_chg;

    always_comb begin
        next_val         = wr_data;
        next_val[CR0_ET] = 1'b1;
    end

    always_comb begin
        pg_chg    = next_val[CR0_PG] ^ cr0_q[CR0_PG];
        wp_chg    = next_val[CR0_WP] ^ cr0_q[CR0_WP];
        pe_chg    = next_val[CR0_PE] ^ cr0_q[CR0_PE];
        flush_req = wr & (pg_chg | wp_chg | pe_chg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q   <= RESET_VAL;
            flags_q <= derive_cr0_flags(RESET_VAL[3:0]);
        end else if (wr) begin
            cr0_q   <= next_val;
            flags_q <= derive_cr0_flags(next_val[3:0]);
        end
    end

endmodule

// File: rtl/crw_cr4_unit.sv
module crw_cr4_unit
    import crw_pkg::*;
#(
    parameter int DATA_W = CRW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sse_supported,
    output logic [DATA_W-1:0] cr4_q,
    output logic              osfxsr_q,
    output logic              flush_req
);

    logic [DATA_W-1:0] next_val;

    always_comb begin
        next_val = wr_data;
        if (!sse_supported) begin
            next_val[CR4_OSFXSR] = 1'b0;
        end
    end

    always_comb begin
        flush_req = wr & ((next_val[CR4_PGE] ^ cr4_q[CR4_PGE]) |
                          (next_val[CR4_PAE] ^ cr4_q[CR4_PAE]) |
                          (next_val[CR4_PSE] ^ cr4_q[CR4_PSE]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr4_q    <= '0;
            osfxsr_q <= 1'b0;
        end else if (wr) begin
            cr4_q    <= next_val;
            osfxsr_q <= next_val[CR4_OSFXSR];
        end
    end

endmodule

// File: rtl/crw_a20_gate.sv
module crw_a20_gate #(
    parameter int DATA_W  = 32,
    parameter int GATE_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a20_enable,
    output logic [DATA_W-1:0] a20_mask,
    output logic              change_req
);

    logic state_q;

    assign change_req = (a20_enable != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b1;
        end else if (change_req) begin
            state_q <= a20_enable;
        end
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        if (i == GATE_BIT) begin : g_gate
            assign a20_mask[i] = state_q;
        end else begin : g_pass
            assign a20_mask[i] = 1'b1;
        end
    end

endmodule

// File: rtl/crw_flush_ctrl.sv
module crw_flush_ctrl
    import crw_pkg::*;
#(
    parameter int N_FULL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_FULL-1:0] full_src,
    input  logic              ng_src,
    input  logic              exit_src,
    output logic              flush_all,
    output logic              flush_nonglobal,
    output logic              exit_exec
);

    flush_req_t req;
    flush_req_t req_q;

    always_comb begin
        req = merge_flush(|full_src, ng_src, exit_src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req;
        end
    end

    assign flush_all       = req_q.full;
    assign flush_nonglobal = req_q.nonglobal;
    assign exit_exec       = req_q.exit_exec;

endmodule

// File: rtl/crw_ctrl_regs.sv
module crw_ctrl_regs
    import crw_pkg::*;
#(
    parameter int DATA_W   = CRW_W,
    parameter int GATE_BIT = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sse_supported,
    input  logic              a20_enable,
    output logic [DATA_W-1:0] cr0_q,
    output logic [DATA_W-1:0] cr3_q,
    output logic [DATA_W-1:0] cr4_q,
    output logic [DATA_W-1:0] a20_mask,
    output logic              hf_pe,
    output logic              hf_addseg,
    output logic              hf_mp,
    output logic              hf_em,
    output logic              hf_ts,
    output logic              hf_osfxsr,
    output logic              flush_all,
    output logic              flush_nonglobal,
    output logic              exit_exec
);

    localparam int N_FULL = 3;

    crw_sel_e   sel;
    logic       wr_cr0;
    logic       wr_cr3;
    logic       wr_cr4;
    logic       cr0_flush;
    logic       cr4_flush;
    logic       a20_change;
    logic       cr3_flush;
    cr0_flags_t cr0_flags;

    assign sel    = crw_sel_e'(wr_sel);
    assign wr_cr0 = wr_en && (sel == SEL_CR0);
    assign wr_cr3 = wr_en && (sel == SEL_CR3);
    assign wr_cr4 = wr_en && (sel == SEL_CR4);

    crw_cr0_unit #(.DATA_W(DATA_W)) u_cr0 (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_cr0),
        .wr_data   (wr_data),
        .cr0_q     (cr0_q),
        .flags_q   (cr0_flags),
        .flush_req (cr0_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr3_q <= '0;
        end else if (wr_cr3) begin
            cr3_q <= wr_data;
        end
    end

    assign cr3_flush = wr_cr3 & cr0_q[CR0_PG];

    crw_cr4_unit #(.DATA_W(DATA_W)) u_cr4 (
        .clk           (clk),
        .rst           (rst),
        .wr            (wr_cr4),
        .wr_data       (wr_data),
        .sse_supported (sse_supported),
        .cr4_q         (cr4_q),
        .osfxsr_q      (hf_osfxsr),
        .flush_req     (cr4_flush)
    );

    crw_a20_gate #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_a20 (
        .clk        (clk),
        .rst        (rst),
        .a20_enable (a20_enable),
        .a20_mask   (a20_mask),
        .change_req (a20_change)
    );

    crw_flush_ctrl #(.N_FULL(N_FULL)) u_flush (
        .clk             (clk),
        .rst             (rst),
        .full_src        ({a20_change, cr4_flush, cr0_flush}),
        .ng_src          (cr3_flush),
        .exit_src        (a20_change),
        .flush_all       (flush_all),
        .flush_nonglobal (flush_nonglobal),
        .exit_exec       (exit_exec)
    );

    assign hf_pe     = cr0_flags.pe;
    assign hf_addseg = cr0_flags.addseg;
    assign hf_mp     = cr0_flags.mp;
    assign hf_em     = cr0_flags.em;
    assign hf_ts     = cr0_flags.ts;

endmodule

// File: rtl/crw_ctrl_regs_chk.sv
module crw_ctrl_regs_chk #(
    parameter int DATA_W   = 32,
    parameter int GATE_BIT = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic              sse_supported,
    input logic [DATA_W-1:0] cr0_q,
    input logic [DATA_W-1:0] cr3_q,
    input logic [DATA_W-1:0] cr4_q,
    input logic [DATA_W-1:0] a20_mask,
    input logic              hf_pe,
    input logic              hf_osfxsr,
    input logic              flush_all,
    input logic              flush_nonglobal,
    input logic              exit_exec
);

    // R2: bit 4 of the mode register is never seen clear
    a_r2_et_forced: assert property (@(posedge clk) disable iff (rst)
        cr0_q[4]);

    // R3: a write changing a protection bit leads to a full flush
    a_r3_cr0_flush: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd0 &&
         ((wr_data[31] ^ cr0_q[31]) || (wr_data[16] ^ cr0_q[16]) || (wr_data[0] ^ cr0_q[0])))
        |=> flush_all);

    // R4: hidden protection flag tracks the stored bit
    a_r4_pe_mirror: assert property (@(posedge clk) disable iff (rst)
        hf_pe == cr0_q[0]);

    // R6: table base write with paging off never asks for a flush
    a_r6_cr3_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1 && !cr0_q[31]) |=> !flush_nonglobal);

    // R8: without the feature the save-enable bit stays clear
    a_r8_osfxsr_mask: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2 && !sse_supported) |=> (!cr4_q[9] && !hf_osfxsr));

    // R9: only the gated bit of the mask may ever be clear
    a_r9_mask_shape: assert property (@(posedge clk) disable iff (rst)
        (a20_mask | (DATA_W'(1) << GATE_BIT)) == {DATA_W{1'b1}});

    // R9: an exit request always comes with a full flush
    a_r9_exit_with_flush: assert property (@(posedge clk) disable iff (rst)
        exit_exec |-> flush_all);

    // R10: the two flush kinds are never raised together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(flush_all && flush_nonglobal));

    // R11: unused selector leaves every register alone
    a_r11_rsvd_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3) |=> ($stable(cr0_q) && $stable(cr3_q) && $stable(cr4_q)));

endmodule

bind crw_ctrl_regs crw_ctrl_regs_chk #(.DATA_W(DATA_W), .GATE_BIT(GATE_BIT)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .wr_en           (wr_en),
    .wr_sel          (wr_sel),
    .wr_data         (wr_data),
    .sse_supported   (sse_supported),
    .cr0_q           (cr0_q),
    .cr3_q           (cr3_q),
    .cr4_q           (cr4_q),
    .a20_mask        (a20_mask),
    .hf_pe           (hf_pe),
    .hf_osfxsr       (hf_osfxsr),
    .flush_all       (flush_all),
    .flush_nonglobal (flush_nonglobal),
    .exit_exec       (exit_exec)
);

// File: tb/crw_ctrl_regs_bench.sv
module crw_ctrl_regs_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        sse_supported = 1'b1;
    logic        a20_enable = 1'b1;
    logic [31:0] cr0_q, cr3_q, cr4_q, a20_mask;
    logic        hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr;
    logic        flush_all, flush_nonglobal, exit_exec;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    crw_ctrl_regs u_crw_ctrl_regs (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .sse_supported (sse_supported), .a20_enable (a20_enable),
        .cr0_q (cr0_q), .cr3_q (cr3_q), .cr4_q (cr4_q), .a20_mask (a20_mask),
        .hf_pe (hf_pe), .hf_addseg (hf_addseg), .hf_mp (hf_mp), .hf_em (hf_em),
        .hf_ts (hf_ts), .hf_osfxsr (hf_osfxsr), .flush_all (flush_all),
        .flush_nonglobal (flush_nonglobal), .exit_exec (exit_exec)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic strobes(input string req, input logic fa, input logic ng, input logic ex);
        chk(req, "flush_all", {31'd0, flush_all}, {31'd0, fa});
        chk(req, "flush_nonglobal", {31'd0, flush_nonglobal}, {31'd0, ng});
        chk(req, "exit_exec", {31'd0, exit_exec}, {31'd0, ex});
    endtask

    // drive at falling edge, return just after the accepting rising edge
    task automatic do_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R1", "cr0", cr0_q, 32'h6000_0010);
        chk("R1", "cr3", cr3_q, 32'h0);
        chk("R1", "cr4", cr4_q, 32'h0);
        chk("R1", "a20_mask", a20_mask, 32'hFFFF_FFFF);
        chk("R1", "flags pe,addseg,mp,em,ts,osfxsr",
            {26'd0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr}, 32'b010000);
        strobes("R1", 0, 0, 0);
    endtask

    task automatic t_cr0();
        do_write(2'd0, 32'h0);
        chk("R2", "cr0 et forced", cr0_q, 32'h0000_0010);
        strobes("R3", 0, 0, 0);
        chk("R4", "addseg real mode", {31'd0, hf_addseg}, 32'd1);
        do_write(2'd0, 32'h0000_000F);
        chk("R2", "cr0", cr0_q, 32'h0000_001F);
        strobes("R3", 1, 0, 0);
        chk("R4", "pe,addseg", {30'd0, hf_pe, hf_addseg}, 32'b10);
        chk("R5", "mp,em,ts", {29'd0, hf_mp, hf_em, hf_ts}, 32'b111);
        next_cycle();
        strobes("R10", 0, 0, 0);
        do_write(2'd0, 32'h0000_000B);
        strobes("R3", 0, 0, 0);
        chk("R5", "mp,em,ts", {29'd0, hf_mp, hf_em, hf_ts}, 32'b101);
        do_write(2'd0, 32'h0001_000B);
        strobes("R3", 1, 0, 0);
        chk("R2", "cr0 wp", cr0_q, 32'h0001_001B);
    endtask

    task automatic t_cr3();
        do_write(2'd1, 32'h1234_5000);
        chk("R6", "cr3 paging off", cr3_q, 32'h1234_5000);
        strobes("R6", 0, 0, 0);
        do_write(2'd0, 32'h8001_000B);
        strobes("R3", 1, 0, 0);
        do_write(2'd1, 32'hABCD_E000);
        chk("R6", "cr3 paging on", cr3_q, 32'hABCD_E000);
        strobes("R6", 0, 1, 0);
        next_cycle();
        strobes("R10", 0, 0, 0);
    endtask

    task automatic t_cr4();
        sse_supported = 1'b1;
        do_write(2'd2, 32'h0000_0200);
        chk("R8", "cr4 osfxsr kept", cr4_q, 32'h0000_0200);
        chk("R8", "hf_osfxsr", {31'd0, hf_osfxsr}, 32'd1);
        strobes("R7", 0, 0, 0);
        do_write(2'd2, 32'h0000_0210);
        strobes("R7", 1, 0, 0);
        do_write(2'd2, 32'h0000_0230);
        strobes("R7", 1, 0, 0);
        do_write(2'd2, 32'h0000_02B0);
        strobes("R7", 1, 0, 0);
        do_write(2'd2, 32'h0000_02B1);
        strobes("R7", 0, 0, 0);
        sse_supported = 1'b0;
        do_write(2'd2, 32'h0000_02B1);
        chk("R8", "cr4 osfxsr masked", cr4_q, 32'h0000_00B1);
        chk("R8", "hf_osfxsr", {31'd0, hf_osfxsr}, 32'd0);
        strobes("R7", 0, 0, 0);
        sse_supported = 1'b1;
    endtask

    task automatic t_a20();
        @(negedge clk); a20_enable = 1'b0;
        next_cycle();
        chk("R9", "mask gated", a20_mask, 32'hFFEF_FFFF);
        strobes("R9", 1, 0, 1);
        next_cycle();
        chk("R9", "mask held", a20_mask, 32'hFFEF_FFFF);
        strobes("R9", 0, 0, 0);
        @(negedge clk); a20_enable = 1'b1;
        next_cycle();
        chk("R9", "mask open", a20_mask, 32'hFFFF_FFFF);
        strobes("R9", 1, 0, 1);
        next_cycle();
        strobes("R9", 0, 0, 0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        a20_enable = 1'b0;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h0055_5000;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk("R10", "cr3 stored", cr3_q, 32'h0055_5000);
        strobes("R10", 1, 0, 1);
        next_cycle();
        strobes("R10", 0, 0, 0);
    endtask

    task automatic t_ignored();
        do_write(2'd3, 32'hFFFF_FFFF);
        chk("R11", "cr0", cr0_q, 32'h8001_001B);
        chk("R11", "cr3", cr3_q, 32'h0055_5000);
        chk("R11", "cr4", cr4_q, 32'h0000_00B1);
        strobes("R11", 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        t_reset();
        t_cr0();
        t_cr3();
        t_cr4();
        t_a20();
        t_priority();
        t_ignored();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule